// File: doc/BRIEF.md
# Tiled-Region Fence Register Bank

This block keeps a small bank of fence registers. Each one marks a range of linear aperture pages as tiled memory. Every aperture access address that arrives is compared in parallel against all enabled fences. The block then returns whether a fence covers the address, the index of that fence, whether the region is X- or Y-tiled, and the row stride in bytes decoded from the stored pitch code.

Each fence is 64 bits wide and software writes it as two independent 32-bit halves over a simple register port. The enable flag sits in the low half. This allows a safe update sequence: clear the low half first, rewrite the high half, and write the low half with the enable flag set last. During that sequence a half-written fence never takes part in matching. Every half can be read back over the same port, so software can confirm that a write has landed. If more than one enabled fence claims an access, the lowest index wins and a sticky overlap flag is raised.

Top module: `fence_bank`

## Requirements
- R1: After reset every register half reads back as zero, no lookup reports a hit, and `overlap_err` is low.
- R2: A write with `reg_wr` high stores `reg_wdata` into the half selected by `reg_addr`. `reg_addr[0]` = 1 selects the high half and `reg_addr[0]` = 0 selects the low half. The upper bits of `reg_addr` give the fence index. A read with `reg_rd` high returns the stored 32-bit value on `reg_rdata`, with `reg_rvld` high one cycle later.
- R3: A fence whose enable flag (low half bit 0) is clear never matches, whatever its address fields hold. A lookup that misses returns index 0, X tiling and a stride of 0.
- R4: A fence matches when its start page ≤ the access page ≤ its last page. The start page is low half bits [31:12], the last page is high half bits [31:12], and the access page is `lk_addr[31:12]`. Bits [11:0] of the access address have no effect.
- R5: When several enabled fences match, the reported index is the lowest matching index.
- R6: A lookup matched by two or more enabled fences sets `overlap_err`. The flag stays set until reset, including across later lookups that do not overlap.
- R7: Low half bit 1 set reports Y tiling (`res_ytile` = 1). When it is clear, a matching fence reports X tiling (`res_ytile` = 0).
- R8: The pitch code in low half bits [11:2] decodes to a stride of (code + 1) × 128 bytes on `res_stride`. This covers code 0 (128 B) through 1023 (131072 B).
- R9: Each lookup with `lk_valid` high gives exactly one result, with `res_vld` high in the following cycle. `res_vld` is low after a cycle with no lookup.
- R10: Consider a fence disabled by writing zero to its low half. Rewriting its high half has no effect on matching. Once the low half is rewritten with the enable flag set, the new range applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | IDX_W+1 | {fence index, half select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvld | output | 1 | Read data valid |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Aperture access address |
| res_vld | output | 1 | Lookup result valid |
| res_hit | output | 1 | A fence covers the address |
| res_idx | output | IDX_W | Winning fence index |
| res_ytile | output | 1 | 1 = Y tiling, 0 = X tiling |
| res_stride | output | 18 | Decoded row stride in bytes |
| overlap_err | output | 1 | Sticky overlap indication |

## Verification
The properties assume that `reg_wr` and `reg_rd` are never asserted in the same cycle. They also assume that the register index is within the bank, so that every read is answered. The stimulus issues one register operation or one lookup per cycle and uses only fence indices that exist. Overlapping fences are created on purpose only in the part that targets the sticky flag. Result fields are checked only in the cycle after a request.

// File: rtl/fence_pkg.sv
package fence_pkg;
    localparam int WORD_W    = 32;
    localparam int EN_BIT    = 0;
    localparam int YT_BIT    = 1;
    localparam int PCODE_LSB = 2;
    localparam int PCODE_W   = 10;
    localparam int PAGE_LSB  = 12;
    localparam int PAGE_W    = WORD_W - PAGE_LSB;
    localparam int ROW_SHIFT = 7;
    localparam int STRIDE_W  = PCODE_W + 1 + ROW_SHIFT;

    typedef enum logic {
        TILE_X = 1'b0,
        TILE_Y = 1'b1
    } tile_e;
endpackage

// File: rtl/fence_store.sv
module fence_store
    import fence_pkg::*;
#(
    parameter int NUM_FENCES = 8,
    localparam int IDX_W = $clog2(NUM_FENCES),
    localparam int RA_W  = IDX_W + 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr,
    input  logic                                rd,
    input  logic [RA_W-1:0]                     addr,
    input  logic [WORD_W-1:0]                   wdata,
    output logic [NUM_FENCES-1:0][WORD_W-1:0]   lo_words,
    output logic [NUM_FENCES-1:0][WORD_W-1:0]   hi_words,
    output logic [WORD_W-1:0]                   rdata,
    output logic                                rvld
);
    typedef struct packed {
        logic [NUM_FENCES-1:0][WORD_W-1:0] lo;
        logic [NUM_FENCES-1:0][WORD_W-1:0] hi;
        logic [WORD_W-1:0]                 rdata;
        logic                              rvld;
    } store_t;

    store_t st_d, st_q;
    logic [IDX_W-1:0] sel;
    logic             upper;

    assign sel   = addr[RA_W-1:1];
    assign upper = addr[0];

    always_comb begin
        st_d      = st_q;
        st_d.rvld = rd;
        if (wr) begin
            if (upper) st_d.hi[sel] = wdata;
            else       st_d.lo[sel] = wdata;
        end
        if (rd) begin
            st_d.rdata = upper ? st_q.hi[sel] : st_q.lo[sel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_words = st_q.lo;
    assign hi_words = st_q.hi;
    assign rdata    = st_q.rdata;
    assign rvld     = st_q.rvld;
endmodule

// File: rtl/fence_match.sv
module fence_match
    import fence_pkg::*;
#(
    parameter int NUM_FENCES = 8,
    localparam int IDX_W = $clog2(NUM_FENCES)
) (
    input  logic [NUM_FENCES-1:0][WORD_W-1:0] lo_words,
    input  logic [NUM_FENCES-1:0][WORD_W-1:0] hi_words,
    input  logic [WORD_W-1:0]                 addr,
    output logic                              any_hit,
    output logic [IDX_W-1:0]                  win_idx,
    output logic                              multi_hit
);
    logic [NUM_FENCES-1:0] hit_vec;
    logic [PAGE_W-1:0]     page;

    assign page = addr[WORD_W-1:PAGE_LSB];

    for (genvar g = 0; g < NUM_FENCES; g++) begin : g_cmp
        logic [PAGE_W-1:0] first_pg;
        logic [PAGE_W-1:0] last_pg;
        assign first_pg   = lo_words[g][WORD_W-1:PAGE_LSB];
        assign last_pg    = hi_words[g][WORD_W-1:PAGE_LSB];
        assign hit_vec[g] = lo_words[g][EN_BIT]
                            && (page >= first_pg) && (page <= last_pg);
    end

    always_comb begin
        win_idx = '0;
        for (int i = NUM_FENCES - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
    end

    assign any_hit   = |hit_vec;
    assign multi_hit = |(hit_vec & (hit_vec - NUM_FENCES'(1)));
endmodule

// File: rtl/fence_pitch_dec.sv
module fence_pitch_dec
    import fence_pkg::*;
(
    input  logic [WORD_W-1:0]   lo_word,
    output tile_e               tile,
    output logic [STRIDE_W-1:0] stride
);
    logic [PCODE_W-1:0] code;

    assign code   = lo_word[PCODE_LSB +: PCODE_W];
    assign tile   = lo_word[YT_BIT] ? TILE_Y : TILE_X;
    assign stride = (STRIDE_W'(code) + STRIDE_W'(1)) << ROW_SHIFT;
endmodule

// File: rtl/fence_bank.sv
module fence_bank
    import fence_pkg::*;
#(
    parameter int NUM_FENCES = 8,
    localparam int IDX_W = $clog2(NUM_FENCES),
    localparam int RA_W  = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_rvld,
    input  logic                 lk_valid,
    input  logic [31:0]          lk_addr,
    output logic                 res_vld,
    output logic                 res_hit,
    output logic [IDX_W-1:0]     res_idx,
    output logic                 res_ytile,
    output logic [17:0]          res_stride,
    output logic                 overlap_err
);
    typedef struct packed {
        logic                vld;
        logic                hit;
        logic [IDX_W-1:0]    idx;
        logic                ytile;
        logic [STRIDE_W-1:0] stride;
        logic                err;
    } res_t;

    logic [NUM_FENCES-1:0][WORD_W-1:0] lo_words, hi_words;
    logic                any_hit, multi_hit;
    logic [IDX_W-1:0]    win_idx;
    tile_e               win_tile;
    logic [STRIDE_W-1:0] win_stride;
    res_t                res_d, res_q;

    fence_store #(.NUM_FENCES(NUM_FENCES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .lo_words (lo_words),
        .hi_words (hi_words),
        .rdata    (reg_rdata),
        .rvld     (reg_rvld)
    );

    fence_match #(.NUM_FENCES(NUM_FENCES)) u_match (
        .lo_words  (lo_words),
        .hi_words  (hi_words),
        .addr      (lk_addr),
        .any_hit   (any_hit),
        .win_idx   (win_idx),
        .multi_hit (multi_hit)
    );

    fence_pitch_dec u_pdec (
        .lo_word (lo_words[win_idx]),
        .tile    (win_tile),
        .stride  (win_stride)
    );

    always_comb begin
        res_d     = '0;
        res_d.err = res_q.err;
        if (lk_valid) begin
            res_d.vld = 1'b1;
            res_d.hit = any_hit;
            if (any_hit) begin
                res_d.idx    = win_idx;
                res_d.ytile  = (win_tile == TILE_Y);
                res_d.stride = win_stride;
            end
            if (multi_hit) res_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_vld     = res_q.vld;
    assign res_hit     = res_q.hit;
    assign res_idx     = res_q.idx;
    assign res_ytile   = res_q.ytile;
    assign res_stride  = res_q.stride;
    assign overlap_err = res_q.err;
endmodule

// File: rtl/fence_bank_chk.sv
module fence_bank_chk #(
    parameter int NUM_FENCES = 8,
    localparam int IDX_W = $clog2(NUM_FENCES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic             reg_rvld,
    input logic             lk_valid,
    input logic             res_vld,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic             res_ytile,
    input logic [17:0]      res_stride,
    input logic             overlap_err
);
    a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_vld);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_vld);
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvld);
    a_r2_read_only_when_asked: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvld);
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err);
    a_r3_miss_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_idx == '0 && !res_ytile && res_stride == '0));
    a_r8_hit_stride_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_hit) |-> (res_stride != '0 && res_stride[6:0] == 7'd0));
endmodule

bind fence_bank fence_bank_chk #(.NUM_FENCES(NUM_FENCES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd      (reg_rd),
    .reg_rvld    (reg_rvld),
    .lk_valid    (lk_valid),
    .res_vld     (res_vld),
    .res_hit     (res_hit),
    .res_idx     (res_idx),
    .res_ytile   (res_ytile),
    .res_stride  (res_stride),
    .overlap_err (overlap_err)
);

// File: tb/fence_bank_tb.sv
module fence_bank_tb;
    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0, reg_rd = 1'b0, lk_valid = 1'b0;
    logic [IDX_W:0]   reg_addr = '0;
    logic [31:0]      reg_wdata = '0, lk_addr = '0;
    logic [31:0]      reg_rdata;
    logic             reg_rvld, res_vld, res_hit, res_ytile, overlap_err;
    logic [IDX_W-1:0] res_idx;
    logic [17:0]      res_stride;

    always #5 clk = ~clk;

    fence_bank #(.NUM_FENCES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvld(reg_rvld), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx),
        .res_ytile(res_ytile), .res_stride(res_stride), .overlap_err(overlap_err)
    );

    typedef struct packed {
        logic        hit;
        logic [7:0]  idx;
        logic        ytile;
        logic [17:0] stride;
        logic [7:0]  req;
    } lk_exp_t;

    typedef struct packed {
        logic [31:0] data;
        logic [7:0]  req;
    } rd_exp_t;

    lk_exp_t lk_q[$];
    rd_exp_t rd_q[$];
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic        m_err = 1'b0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_word(input logic [19:0] pg, input bit y,
                                            input logic [9:0] code, input bit en);
        return {pg, code, y, en};
    endfunction

    task automatic reg_write(input int idx, input bit upper, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {IDX_W'(idx), upper}; reg_wdata = d;
        if (upper) m_hi[idx] = d; else m_lo[idx] = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int idx, input bit upper, input int req);
        rd_exp_t e;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = {IDX_W'(idx), upper};
        e.data = upper ? m_hi[idx] : m_lo[idx];
        e.req  = 8'(req);
        rd_q.push_back(e);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input int req);
        lk_exp_t e;
        int nhit = 0;
        e = '0;
        e.req = 8'(req);
        for (int i = 0; i < N; i++) begin
            if (m_lo[i][0] && a[31:12] >= m_lo[i][31:12] && a[31:12] <= m_hi[i][31:12]) begin
                if (nhit == 0) begin
                    e.hit    = 1'b1;
                    e.idx    = 8'(i);
                    e.ytile  = m_lo[i][1];
                    e.stride = (18'(m_lo[i][11:2]) + 18'd1) * 18'd128;
                end
                nhit++;
            end
        end
        if (nhit > 1) m_err = 1'b1;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        lk_q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check(lk_q.size() == 0 && rd_q.size() == 0, 9, 32'(lk_q.size()), 32'd0);
    endtask

    // Monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_vld) begin
                if (lk_q.size() == 0) check(1'b0, 9, 32'd1, 32'd0);
                else begin
                    lk_exp_t e;
                    e = lk_q.pop_front();
                    check(res_hit == e.hit, int'(e.req), 32'(res_hit), 32'(e.hit));
                    check(32'(res_idx) == 32'(e.idx), int'(e.req), 32'(res_idx), 32'(e.idx));
                    check(res_ytile == e.ytile, int'(e.req), 32'(res_ytile), 32'(e.ytile));
                    check(res_stride == e.stride, int'(e.req), 32'(res_stride), 32'(e.stride));
                end
            end
            if (reg_rvld) begin
                if (rd_q.size() == 0) check(1'b0, 2, 32'd1, 32'd0);
                else begin
                    rd_exp_t r;
                    r = rd_q.pop_front();
                    check(reg_rdata == r.data, int'(r.req), reg_rdata, r.data);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!res_vld && !overlap_err, 1, {res_vld, overlap_err}, 32'd0);
        reg_read(0, 0, 1);
        reg_read(3, 1, 1);
        reg_read(N - 1, 0, 1);
        lookup(32'h0010_0000, 1);
        drain();

        // R10 ordered update of fence 0: pages 0x100..0x10F, X, code 3
        reg_write(0, 0, 32'd0);
        reg_write(0, 1, {20'h0010F, 12'hABC});
        reg_write(0, 0, lo_word(20'h00100, 1'b0, 10'd3, 1'b1));
        // R2: readback of both halves
        reg_read(0, 1, 2);
        reg_read(0, 0, 2);
        // R4: inclusive bounds, low 12 bits ignored
        lookup(32'h0010_0000, 4);
        lookup(32'h0010_FFFF, 4);
        lookup(32'h0011_0000, 4);
        lookup(32'h000F_FFFF, 4);
        lookup(32'h0010_7123, 4);
        // R7, R8: Y tiling, smallest and largest pitch codes
        reg_write(2, 1, {20'h0020F, 12'h000});
        reg_write(2, 0, lo_word(20'h00200, 1'b1, 10'd0, 1'b1));
        reg_write(5, 1, {20'h00500, 12'h000});
        reg_write(5, 0, lo_word(20'h00500, 1'b0, 10'h3FF, 1'b1));
        lookup(32'h0020_4000, 7);
        lookup(32'h0050_0FFF, 8);
        // R3: disabled fence with a range never matches
        reg_write(1, 1, {20'h0030F, 12'h000});
        reg_write(1, 0, lo_word(20'h00300, 1'b1, 10'd7, 1'b0));
        lookup(32'h0030_5000, 3);
        reg_read(1, 0, 2);
        // R10: disable fence 2, widen it, confirm no match until re-enabled
        reg_write(2, 0, 32'd0);
        lookup(32'h0020_4000, 10);
        reg_write(2, 1, {20'h002FF, 12'h000});
        lookup(32'h0025_0000, 10);
        reg_write(2, 0, lo_word(20'h00200, 1'b1, 10'd15, 1'b1));
        lookup(32'h0025_0000, 10);
        drain();
        check(overlap_err == 1'b0, 6, 32'(overlap_err), 32'd0);

        // R5, R6: fence 3 overlaps fence 0 on pages 0x108..0x10F
        reg_write(3, 1, {20'h00120, 12'h000});
        reg_write(3, 0, lo_word(20'h00108, 1'b1, 10'd1, 1'b1));
        lookup(32'h0011_8000, 6);
        drain();
        check(overlap_err == 1'b0, 6, 32'(overlap_err), 32'(m_err));
        lookup(32'h0010_A000, 5);
        drain();
        check(overlap_err == m_err && m_err, 6, 32'(overlap_err), 32'(m_err));
        lookup(32'h0011_8000, 6);
        lookup(32'h0090_0000, 6);
        drain();
        check(overlap_err == 1'b1, 6, 32'(overlap_err), 32'd1);
        // R9: back-to-back lookups, each answered once
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h0050_0000;
        lk_q.push_back('{1'b1, 8'd5, 1'b0, 18'd131072, 8'd9});
        @(negedge clk);
        lk_addr = 32'h0000_0000;
        lk_q.push_back('{1'b0, 8'd0, 1'b0, 18'd0, 8'd9});
        @(negedge clk);
        lk_valid = 1'b0;
        drain();
        finish_run();
    end
endmodule